// File: doc/BRIEF.md
# AFSK Phase-Accumulator Tone Generator

This block produces a two-tone audio-frequency-shift-keyed waveform for a 1200 baud link. Its output is a stream of 8-bit unsigned samples meant for a parallel or resistor-ladder DAC. A two-stage timer sets the sample rate: a prescaler divides the system clock into timer steps, and a sample counter divides the timer steps into sample ticks. On each sample tick an 8-bit phase accumulator advances by one of two increments. The serial data bit picks the increment and so the tone. The low seven phase bits address a computed half-wave sine table, and the top phase bit decides whether the table value is added to mid-scale or subtracted from it.

The block transmits only while the active-low push-to-talk input is held low. While push-to-talk is released the output sits at a fixed bias code, the sample timer is held at its start, and the phase is kept. Because the phase is never cleared when the tone changes, frequency switches are phase-continuous. Framing, line coding and bit timing of the data input belong to the surrounding logic.

Top module: `afsk_tone_gen`

## Requirements
- R1: While ptt_n is low, a sample tick occurs once every PRESCALE*(256-RELOAD) system clocks (38 with the defaults PRESCALE=2, RELOAD=0xED). The first tick comes that many clocks after ptt_n is first sampled low, so the output first changes at that many rising edges after ptt_n goes low.
- R2: On a sample tick with data_i low (mark, 1200 Hz), the phase advances by 0x10.
- R3: On a sample tick with data_i high (space, about 2200 Hz), the phase advances by 0x1E.
- R4: The phase is 8 bits and wraps modulo 256. It changes only on sample ticks, keeps its value across tone changes and push-to-talk release, and is cleared only by reset.
- R5: The table entry for index i (0..127) is floor(63*16*p / (81920 - 4*p)) with p = i*(128-i). The entries rise from 0 to 63 at index 64 and fall back to 1 at index 127. The table is addressed by phase bits [6:0].
- R6: On a sample tick the output becomes 0x80 + entry when bit 7 of the updated phase is 0, and 0x80 - entry when that bit is 1. The updated phase is the value after this tick's step.
- R7: When ptt_n is sampled high, sample_o reads the idle code 0x73 from the next clock onward and the sample timer restarts.
- R8: While rst_n is low, sample_o is 0x73 and the phase is cleared to 0. The first tick after reset with data_i low therefore gives the output for phase 0x10.
- R9: While ptt_n stays low, sample_o changes only at a sample tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptt_n | input | 1 | Active-low push-to-talk; transmission runs only while low |
| data_i | input | 1 | Serial data bit: 0 selects mark tone, 1 selects space tone |
| sample_o | output | 8 | Registered unsigned DAC sample |

## Verification
The bench times the first sample after push-to-talk goes low. A timer that is not restarted, or one that is off by one, shows up as an early or late change from the idle code. A reference model steps the phase through long random runs of tone changes and releases, so the phase wraps many times. A design that cleared the phase on a tone change or on a release, swapped the two increments, or computed the output from the pre-step phase would drift away from the model within a sample. Directed checks then look at the idle code on release, the sign choice about mid-scale for phases above 0x80, and the clearing of the phase by a reset taken in the middle of a transmission.

// File: rtl/afsk_pkg.sv
// Package: shared constants and the half-wave table generator for the AFSK tone generator.
// Assumes the table function is only evaluated at elaboration to build constants.
package afsk_pkg;

    localparam int          SAMPLE_W  = 8;
    localparam logic [7:0]  IDLE_CODE = 8'h73;
    localparam logic [7:0]  MARK_STEP = 8'h10;
    localparam logic [7:0]  SPACE_STEP = 8'h1E;
    localparam int          TABLE_AMP = 63;

    // Rational half-sine approximation: amp*16*p/(5*d*d - 4*p), p = i*(d-i).
    function automatic int half_sine(input int idx, input int depth, input int amp);
        int p;
        p = idx * (depth - idx);
        return (amp * 16 * p) / (5 * depth * depth - 4 * p);
    endfunction

endpackage

// File: rtl/afsk_sample_timer.sv
// Sample timer: a prescaler turns system clocks into timer steps, and a down-counter
// turns (2**TW - RELOAD) timer steps into one sample tick.
// Assumes run_i is synchronous; both stages are held at their start while run_i is low.
module afsk_sample_timer #(
    parameter int PRESCALE = 2,
    parameter int TW       = 8,
    parameter int RELOAD   = 237
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);

    localparam int TICKS = (1 << TW) - RELOAD;
    localparam int PCW   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int SCW   = (TICKS > 1) ? $clog2(TICKS) : 1;

    logic timer_step;

    generate
        if (PRESCALE > 1) begin : g_pre
            localparam logic [PCW-1:0] PRE_LAST = PCW'(PRESCALE - 1);
            logic [PCW-1:0] pre_q;

            // Prescaler counting system clocks per timer step.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i)       pre_q <= '0;
                else if (pre_q == PRE_LAST) pre_q <= '0;
                else                        pre_q <= pre_q + 1'b1;
            end

            assign timer_step = run_i && (pre_q == PRE_LAST);
        end else begin : g_nopre
            assign timer_step = run_i;
        end
    endgenerate

    generate
        if (TICKS > 1) begin : g_cnt
            localparam logic [SCW-1:0] CNT_LOAD = SCW'(TICKS - 1);
            logic [SCW-1:0] cnt_q;

            // Down-counter of timer steps per sample.
            always_ff @(posedge clk) begin
                if (!rst_n || !run_i) cnt_q <= CNT_LOAD;
                else if (timer_step) begin
                    if (cnt_q == '0) cnt_q <= CNT_LOAD;
                    else             cnt_q <= cnt_q - 1'b1;
                end
            end

            assign tick_o = timer_step && (cnt_q == '0);
        end else begin : g_nocnt
            assign tick_o = timer_step;
        end
    endgenerate

endmodule

// File: rtl/afsk_phase_acc.sv
// Phase accumulator: on each step adds the mark or space increment, wrapping modulo 2**PW.
// Assumes step_i is a single-cycle enable; phase is cleared only by reset.
module afsk_phase_acc #(
    parameter int             PW         = 8,
    parameter logic [PW-1:0]  MARK_INC   = PW'(8'h10),
    parameter logic [PW-1:0]  SPACE_INC  = PW'(8'h1E)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_i,
    input  logic          tone_hi_i,
    output logic [PW-1:0] phase_o,
    output logic [PW-1:0] phase_next_o
);

    logic [PW-1:0] phase_q;

    // Next phase for the tone currently selected.
    always_comb begin
        phase_next_o = phase_q + (tone_hi_i ? SPACE_INC : MARK_INC);
    end

    // Phase register, advanced only on a step.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (step_i) phase_q <= phase_next_o;
    end

    assign phase_o = phase_q;

endmodule

// File: rtl/afsk_sine_map.sv
// Sine mapper: looks up a half-wave table with the low phase bits and mirrors it about
// mid-scale using the phase MSB. The table is built at elaboration from afsk_pkg::half_sine.
// Assumes AMP fits below mid-scale of the SW-bit output.
module afsk_sine_map #(
    parameter int PW  = 8,
    parameter int SW  = 8,
    parameter int AMP = 63
) (
    input  logic [PW-1:0] phase_i,
    output logic [SW-1:0] sample_o
);

    localparam int DEPTH = 1 << (PW - 1);
    localparam int AW    = $clog2(AMP + 1);
    localparam logic [SW-1:0] MID = SW'(1 << (SW - 1));

    logic [AW-1:0] table_w [DEPTH];
    logic [AW-1:0] entry;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_tab
            assign table_w[g] = AW'(afsk_pkg::half_sine(g, DEPTH, AMP));
        end
    endgenerate

    // Table read and sign mirroring about mid-scale.
    always_comb begin
        entry = table_w[phase_i[PW-2:0]];
        if (phase_i[PW-1]) sample_o = MID - SW'(entry);
        else               sample_o = MID + SW'(entry);
    end

endmodule

// File: rtl/afsk_tone_gen.sv
// AFSK tone generator top: timer, phase accumulator, sine mapper and the output register.
// Assumes ptt_n and data_i are synchronous to clk; output rests at the idle code when idle.
module afsk_tone_gen #(
    parameter int PRESCALE = 2,
    parameter int RELOAD   = 237,
    parameter int PW       = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ptt_n,
    input  logic                          data_i,
    output logic [afsk_pkg::SAMPLE_W-1:0] sample_o
);

    import afsk_pkg::*;

    logic                sample_tick;
    logic [PW-1:0]       phase_q;
    logic [PW-1:0]       phase_next;
    logic [SAMPLE_W-1:0] mapped;

    afsk_sample_timer #(
        .PRESCALE (PRESCALE),
        .TW       (8),
        .RELOAD   (RELOAD)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (!ptt_n),
        .tick_o (sample_tick)
    );

    afsk_phase_acc #(
        .PW        (PW),
        .MARK_INC  (PW'(MARK_STEP)),
        .SPACE_INC (PW'(SPACE_STEP))
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (sample_tick),
        .tone_hi_i    (data_i),
        .phase_o      (phase_q),
        .phase_next_o (phase_next)
    );

    afsk_sine_map #(
        .PW  (PW),
        .SW  (SAMPLE_W),
        .AMP (TABLE_AMP)
    ) u_map (
        .phase_i  (phase_next),
        .sample_o (mapped)
    );

    // Output register: idle code when idle, new sample on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || ptt_n) sample_o <= IDLE_CODE;
        else if (sample_tick) sample_o <= mapped;
    end

endmodule

// File: rtl/afsk_tone_gen_chk.sv
// Checker for afsk_tone_gen: timing, stepping, hold and idle-code properties.
// Attached by bind below; a gap counter stands in for the long tick window.
module afsk_tone_gen_chk #(
    parameter int PRESCALE = 2,
    parameter int RELOAD   = 237,
    parameter int PW       = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ptt_n,
    input logic          data_i,
    input logic [7:0]    sample_o,
    input logic          sample_tick,
    input logic [PW-1:0] phase_q
);

    localparam int PERIOD = PRESCALE * (256 - RELOAD);

    int gap_cnt;

    // Clocks since the last tick or since the timer was held.
    always_ff @(posedge clk) begin
        if (!rst_n || ptt_n || sample_tick) gap_cnt <= 0;
        else                                gap_cnt <= gap_cnt + 1;
    end

    // R1
    sample_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> (gap_cnt == PERIOD - 1));

    // R1
    tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> !ptt_n);

    // R2
    mark_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && !data_i) |=> (phase_q == PW'($past(phase_q) + PW'(8'h10))));

    // R3
    space_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && data_i) |=> (phase_q == PW'($past(phase_q) + PW'(8'h1E))));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable(phase_q));

    // R6
    sign_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |=> (phase_q[PW-1] ? (sample_o <= 8'h80) : (sample_o >= 8'h80)));

    // R7
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptt_n |=> (sample_o == 8'h73));

    // R9
    sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && !ptt_n) |=> $stable(sample_o));

endmodule

bind afsk_tone_gen afsk_tone_gen_chk #(
    .PRESCALE (PRESCALE),
    .RELOAD   (RELOAD),
    .PW       (PW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptt_n       (ptt_n),
    .data_i      (data_i),
    .sample_o    (sample_o),
    .sample_tick (sample_tick),
    .phase_q     (phase_q)
);

// File: tb/afsk_tone_gen_test.sv
module afsk_tone_gen_test;

    localparam int PERIOD = 38;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ptt_n = 1'b1;
    logic       data_i = 1'b0;
    logic [7:0] sample_o;

    always #5 clk = ~clk;

    afsk_tone_gen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .ptt_n    (ptt_n),
        .data_i   (data_i),
        .sample_o (sample_o)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    model_on = 1'b0;
    string tag = "R8";

    int         m_clk;
    logic [7:0] m_phase;
    logic [7:0] m_out;

    // Expected sample for a phase, from R5 and R6.
    function automatic logic [7:0] ref_sample(input logic [7:0] ph);
        int i, p, t;
        i = int'(ph[6:0]);
        p = i * (128 - i);
        t = (63 * 16 * p) / (81920 - 4 * p);
        return ph[7] ? 8'(128 - t) : 8'(128 + t);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Reference model: ticks every PERIOD active clocks, restarts on release.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_clk = 0; m_phase = 8'h00; m_out = 8'h73;
        end else if (ptt_n) begin
            m_clk = 0; m_out = 8'h73;
        end else begin
            m_clk = m_clk + 1;
            if (m_clk == PERIOD) begin
                m_clk = 0;
                m_phase = m_phase + (data_i ? 8'h1E : 8'h10);
                m_out = ref_sample(m_phase);
            end
        end
    end

    always @(negedge clk) begin
        if (model_on) check(tag, sample_o, m_out);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R1 watchdog actual timeout expected completion");
            finish_run();
        end
    end

    // Start from phase 0 and time the first two ticks.
    task automatic first_ticks();
        @(negedge clk);
        ptt_n = 1'b0; data_i = 1'b0;
        repeat (PERIOD - 1) @(negedge clk);
        check("R1 no change before period", sample_o, 8'h73);
        @(negedge clk);
        check("R1 R2 R5 first mark sample", sample_o, ref_sample(8'h10));
        data_i = 1'b1;
        repeat (PERIOD) @(negedge clk);
        check("R3 space step sample", sample_o, ref_sample(8'h2E));
    endtask

    initial begin
        void'($urandom(32'h5EED_1200));
        repeat (3) @(negedge clk);
        check("R8 reset idle code", sample_o, 8'h73);
        rst_n = 1'b1;
        model_on = 1'b1;
        tag = "R7 idle before transmit";
        repeat (4) @(negedge clk);

        tag = "R1 R2 R3 model";
        first_ticks();
        check("R5 table peak", ref_sample(8'h40), 8'hBF);
        ptt_n = 1'b1;
        @(negedge clk);
        check("R7 release idle", sample_o, 8'h73);

        // Phase above 0x80 with mark tone: drives negative half.
        tag = "R4 R6 wrap model";
        ptt_n = 1'b0; data_i = 1'b0;
        repeat (PERIOD * 12) @(negedge clk);
        check("R6 negative half", sample_o, ref_sample(8'h2E + 8'h10 * 12));

        tag = "R4 R5 R6 R9 random";
        for (int seg = 0; seg < 1500; seg++) begin
            data_i = 1'($urandom_range(0, 1));
            ptt_n = ($urandom_range(0, 15) == 0);
            repeat ($urandom_range(1, 80)) @(negedge clk);
        end

        // Reset mid-transmission clears the phase.
        tag = "R8 reset";
        ptt_n = 1'b0;
        repeat (PERIOD * 3 + 7) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R8 idle in reset", sample_o, 8'h73);
        ptt_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R8 after reset model";
        first_ticks();
        ptt_n = 1'b1;
        @(negedge clk);
        check("R7 final release", sample_o, 8'h73);
        finish_run();
    end

endmodule